// File: doc/BRIEF.md
# Display Flip Command Controller

This block sits between a command parser and a display engine. It takes a two-word front-buffer flip command from a valid/ready word stream and checks its header. It then extracts the row pitch, the flip kind and the new frame base. The new base reaches the display at a point set by the flip kind. A synchronous flip lands on the next vertical sync and also updates the pitch. An asynchronous flip lands on the next horizontal sync and leaves the pitch alone.

A pending flag tracks each accepted flip, and the command stream stalls while that flag is set. A synchronous flip retires at its commit. An asynchronous flip stays pending until a fixed number of scan lines have passed after its commit, so the display has time to fetch the new surface. Every edge of the pending flag can raise a status-writeback strobe. The falling edge can also latch an interrupt request, which stays set until software clears it.

Top module: `disp_flip_ctrl`

## Requirements
- R1: After reset the base output is 0, the pitch output is 0, the pending flag and interrupt are low, and the command ready is high.
- R2: A first word is accepted only when bits 31:29 are 000, bits 28:23 are 14h and bits 5:0 are 00h. Any other first word gives a one-cycle cmd_err_o pulse in the cycle after the handshake. It changes no base, pitch or pending state, and the next word is again taken as a first word.
- R3: The pitch is taken from first-word bits 19:8 and the flip kind from bit 6 (0 synchronous, 1 asynchronous). The base is taken from second-word bits 25:3, which are quadword address bits 25:3.
- R4: The pending flag rises in the cycle after the second word is accepted. cmd_ready_o is low whenever the flag is set.
- R5: For a synchronous flip, the first clock edge that samples vsync_i high while the flip is pending loads the new base and pitch and clears the pending flag.
- R6: For an asynchronous flip, the first clock edge that samples hsync_i high loads the new base. The pitch is unchanged and the flag stays set.
- R7: After an asynchronous commit, the flag clears at the edge that samples the 32nd following hsync_i pulse, and not earlier.
- R8: The sync that does not govern the pending flip kind has no effect, including when both syncs are high in the same cycle.
- R9: status_wr_o pulses for one cycle in the cycle after each rise or fall of the pending flag, unless hws_mask_i is high.
- R10: irq_o is set at the edge after the flag falls when irq_mask_i is 0 and irq_en_i is 1. It holds until an irq_clr_i pulse, and a set in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | Command word valid |
| cmd_data_i | input | 32 | Command word |
| cmd_ready_o | output | 1 | Command word ready |
| vsync_i | input | 1 | Vertical sync strobe |
| hsync_i | input | 1 | Horizontal sync strobe |
| hws_mask_i | input | 1 | Suppresses status writeback |
| irq_mask_i | input | 1 | Masks the interrupt |
| irq_en_i | input | 1 | Enables the interrupt |
| irq_clr_i | input | 1 | Clears the interrupt request |
| disp_base_o | output | 23 | Display base, quadword address bits 25:3 |
| disp_pitch_o | output | 12 | Display pitch in quadwords |
| flip_pending_o | output | 1 | Flip pending flag |
| status_wr_o | output | 1 | Status writeback request |
| irq_o | output | 1 | Sticky interrupt request |
| cmd_err_o | output | 1 | Rejected command pulse |

## Verification
The two syncs can arrive in the same cycle, and a flip must act only on the sync that governs its kind. The bench drives vsync_i and hsync_i together for flips of both kinds. Before that, it drives the non-governing sync alone. It then checks that the base, the pitch and the pending flag move only as the governing sync dictates. A second collision is between an interrupt set and a software clear in the same cycle. The bench holds irq_clr_i high in the cycle when the set arrives and expects irq_o to stay high.

// File: rtl/disp_flip_pkg.sv
package disp_flip_pkg;
  localparam int PITCH_W     = 12;
  localparam int BASE_LSB    = 3;
  localparam int BASE_MSB    = 25;
  localparam int ADDR_W      = BASE_MSB - BASE_LSB + 1;
  localparam int CLIENT_MSB  = 31;
  localparam int CLIENT_LSB  = 29;
  localparam int TARGET_MSB  = 28;
  localparam int TARGET_LSB  = 23;
  localparam int PITCH_LSB   = 8;
  localparam int KIND_BIT    = 6;
  localparam int LEN_MSB     = 5;
  localparam logic [2:0] CLIENT_PARSER = 3'b000;
  localparam logic [5:0] TARGET_FLIP   = 6'h14;
  localparam logic [5:0] LEN_FLIP      = 6'h00;

  typedef enum logic {FLIP_SYNC = 1'b0, FLIP_ASYNC = 1'b1} flip_kind_e;

  typedef struct packed {
    flip_kind_e          kind;
    logic [PITCH_W-1:0]  pitch;
    logic [ADDR_W-1:0]   base;
  } flip_cmd_t;
endpackage

// File: rtl/flip_cmd_decode.sv
module flip_cmd_decode
  import disp_flip_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       valid_i,
  input  logic [31:0] data_i,
  input  logic       busy_i,
  output logic       ready_o,
  output logic       cmd_stb_o,
  output flip_cmd_t  cmd_o,
  output logic       err_o
);
  logic               second_q;
  logic [PITCH_W-1:0] pitch_q;
  flip_kind_e         kind_q;
  logic               err_q;
  logic               fire;
  logic               hdr_ok;
  logic               unused_bits;

  assign ready_o = !busy_i;
  assign fire    = valid_i && ready_o;
  assign hdr_ok  = (data_i[CLIENT_MSB:CLIENT_LSB] == CLIENT_PARSER) &&
                   (data_i[TARGET_MSB:TARGET_LSB] == TARGET_FLIP) &&
                   (data_i[LEN_MSB:0] == LEN_FLIP);
  assign unused_bits = ^{data_i[22:20], data_i[7], data_i[2:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      second_q <= 1'b0;
      pitch_q  <= '0;
      kind_q   <= FLIP_SYNC;
      err_q    <= 1'b0;
    end else begin
      err_q <= fire && !second_q && !hdr_ok;
      if (fire) begin
        if (!second_q) begin
          if (hdr_ok) begin
            second_q <= 1'b1;
            pitch_q  <= data_i[PITCH_LSB+PITCH_W-1:PITCH_LSB];
            kind_q   <= data_i[KIND_BIT] ? FLIP_ASYNC : FLIP_SYNC;
          end
        end else begin
          second_q <= 1'b0;
        end
      end
    end
  end

  assign cmd_stb_o   = fire && second_q;
  assign cmd_o.kind  = kind_q;
  assign cmd_o.pitch = pitch_q;
  assign cmd_o.base  = data_i[BASE_MSB:BASE_LSB];
  assign err_o       = err_q;
endmodule

// File: rtl/flip_commit.sv
module flip_commit
  import disp_flip_pkg::*;
#(
  parameter int LINES = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cmd_stb_i,
  input  flip_cmd_t          cmd_i,
  input  logic               vsync_i,
  input  logic               hsync_i,
  output logic [ADDR_W-1:0]  base_o,
  output logic [PITCH_W-1:0] pitch_o,
  output logic               pending_o
);
  localparam int CNT_W = (LINES > 1) ? $clog2(LINES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LINES - 1);

  flip_cmd_t          stg_q;
  logic               pend_q;
  logic               armed_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [ADDR_W-1:0]  base_q;
  logic [PITCH_W-1:0] pitch_q;
  logic               sync_hit;
  logic               async_hit;

  assign sync_hit  = armed_q && (stg_q.kind == FLIP_SYNC) && vsync_i;
  assign async_hit = armed_q && (stg_q.kind == FLIP_ASYNC) && hsync_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q   <= '0;
      pend_q  <= 1'b0;
      armed_q <= 1'b0;
      cnt_q   <= '0;
      base_q  <= '0;
      pitch_q <= '0;
    end else if (cmd_stb_i) begin
      stg_q   <= cmd_i;
      pend_q  <= 1'b1;
      armed_q <= 1'b1;
      cnt_q   <= '0;
    end else if (pend_q) begin
      if (sync_hit) begin
        base_q  <= stg_q.base;
        pitch_q <= stg_q.pitch;
        pend_q  <= 1'b0;
        armed_q <= 1'b0;
      end else if (async_hit) begin
        base_q  <= stg_q.base;
        armed_q <= 1'b0;
        cnt_q   <= '0;
      end else if (!armed_q && hsync_i) begin
        // retire window after async commit
        if (cnt_q == CNT_LAST) pend_q <= 1'b0;
        else                   cnt_q  <= cnt_q + 1'b1;
      end
    end
  end

  assign base_o    = base_q;
  assign pitch_o   = pitch_q;
  assign pending_o = pend_q;
endmodule

// File: rtl/flip_event.sv
module flip_event (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pending_i,
  input  logic hws_mask_i,
  input  logic irq_mask_i,
  input  logic irq_en_i,
  input  logic irq_clr_i,
  output logic status_wr_o,
  output logic irq_o
);
  logic pend_d_q;
  logic irq_q;
  logic rise;
  logic fall;

  assign rise = pending_i && !pend_d_q;
  assign fall = !pending_i && pend_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_d_q <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      pend_d_q <= pending_i;
      if (fall && !irq_mask_i && irq_en_i) irq_q <= 1'b1;
      else if (irq_clr_i)                  irq_q <= 1'b0;
    end
  end

  assign status_wr_o = (rise || fall) && !hws_mask_i;
  assign irq_o       = irq_q;
endmodule

// File: rtl/disp_flip_ctrl.sv
module disp_flip_ctrl
  import disp_flip_pkg::*;
#(
  parameter int LINES = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cmd_valid_i,
  input  logic [31:0]        cmd_data_i,
  output logic               cmd_ready_o,
  input  logic               vsync_i,
  input  logic               hsync_i,
  input  logic               hws_mask_i,
  input  logic               irq_mask_i,
  input  logic               irq_en_i,
  input  logic               irq_clr_i,
  output logic [ADDR_W-1:0]  disp_base_o,
  output logic [PITCH_W-1:0] disp_pitch_o,
  output logic               flip_pending_o,
  output logic               status_wr_o,
  output logic               irq_o,
  output logic               cmd_err_o
);
  flip_cmd_t cmd;
  logic      cmd_stb;
  logic      pending;

  flip_cmd_decode i_decode (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (cmd_valid_i),
    .data_i    (cmd_data_i),
    .busy_i    (pending),
    .ready_o   (cmd_ready_o),
    .cmd_stb_o (cmd_stb),
    .cmd_o     (cmd),
    .err_o     (cmd_err_o)
  );

  flip_commit #(.LINES(LINES)) i_commit (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cmd_stb_i (cmd_stb),
    .cmd_i     (cmd),
    .vsync_i   (vsync_i),
    .hsync_i   (hsync_i),
    .base_o    (disp_base_o),
    .pitch_o   (disp_pitch_o),
    .pending_o (pending)
  );

  flip_event i_event (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pending_i   (pending),
    .hws_mask_i  (hws_mask_i),
    .irq_mask_i  (irq_mask_i),
    .irq_en_i    (irq_en_i),
    .irq_clr_i   (irq_clr_i),
    .status_wr_o (status_wr_o),
    .irq_o       (irq_o)
  );

  assign flip_pending_o = pending;
endmodule

// File: rtl/disp_flip_chk.sv
module disp_flip_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        cmd_ready_o,
  input logic        flip_pending_o,
  input logic        cmd_err_o,
  input logic [22:0] disp_base_o,
  input logic [11:0] disp_pitch_o,
  input logic        vsync_i,
  input logic        hsync_i,
  input logic        status_wr_o,
  input logic        irq_o,
  input logic        irq_clr_i
);
  p_ready_gate_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flip_pending_o |-> !cmd_ready_o);

  p_reject_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_err_o |-> (!flip_pending_o && $stable(disp_base_o) && $stable(disp_pitch_o)));

  p_base_on_sync_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(disp_base_o) |-> ($past(vsync_i) || $past(hsync_i)));

  p_pitch_vsync_only_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(disp_pitch_o) |-> $past(vsync_i));

  p_retire_on_sync_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flip_pending_o) |-> ($past(vsync_i) || $past(hsync_i)));

  p_wr_on_edge_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_wr_o |-> (flip_pending_o != $past(flip_pending_o)));

  p_irq_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !irq_clr_i) |=> irq_o);
endmodule

bind disp_flip_ctrl disp_flip_chk i_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .cmd_ready_o    (cmd_ready_o),
  .flip_pending_o (flip_pending_o),
  .cmd_err_o      (cmd_err_o),
  .disp_base_o    (disp_base_o),
  .disp_pitch_o   (disp_pitch_o),
  .vsync_i        (vsync_i),
  .hsync_i        (hsync_i),
  .status_wr_o    (status_wr_o),
  .irq_o          (irq_o),
  .irq_clr_i      (irq_clr_i)
);

// File: tb/test_disp_flip_ctrl.sv
`timescale 1ns/1ps
module test_disp_flip_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cmd_valid_i = 1'b0;
  logic [31:0] cmd_data_i = '0;
  logic        cmd_ready_o;
  logic        vsync_i = 1'b0;
  logic        hsync_i = 1'b0;
  logic        hws_mask_i = 1'b0;
  logic        irq_mask_i = 1'b0;
  logic        irq_en_i = 1'b0;
  logic        irq_clr_i = 1'b0;
  logic [22:0] disp_base_o;
  logic [11:0] disp_pitch_o;
  logic        flip_pending_o;
  logic        status_wr_o;
  logic        irq_o;
  logic        cmd_err_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [22:0] m_base = '0;
  logic [11:0] m_pitch = '0;

  always #2 clk_i = ~clk_i;

  disp_flip_ctrl i_disp_flip_ctrl (.*);

  typedef struct packed {
    logic [2:0]  cl;
    logic [5:0]  tg;
    logic [11:0] pitch;
    logic        async_f;
    logic [5:0]  len;
    logic [22:0] base;
    logic        hm;
    logic        im;
    logic        ie;
    logic        both;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 6'h14, 12'h010, 1'b0, 6'd0, 23'h012345, 1'b0, 1'b0, 1'b1, 1'b0},
    '{3'd0, 6'h14, 12'h0A5, 1'b1, 6'd0, 23'h7FFFFF, 1'b0, 1'b0, 1'b1, 1'b1},
    '{3'd1, 6'h14, 12'h333, 1'b0, 6'd0, 23'h000100, 1'b0, 1'b0, 1'b1, 1'b0},
    '{3'd0, 6'h14, 12'hFFF, 1'b0, 6'd0, 23'h000001, 1'b1, 1'b1, 1'b1, 1'b1},
    '{3'd0, 6'h15, 12'h444, 1'b1, 6'd0, 23'h000200, 1'b0, 1'b0, 1'b1, 1'b0},
    '{3'd0, 6'h14, 12'h123, 1'b1, 6'd0, 23'h2AAAAA, 1'b0, 1'b0, 1'b0, 1'b0},
    '{3'd0, 6'h14, 12'h555, 1'b0, 6'd1, 23'h000300, 1'b0, 1'b0, 1'b1, 1'b0}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hs_pulse();
    hsync_i = 1'b1;
    @(negedge clk_i) hsync_i = 1'b0;
  endtask

  task automatic send(input logic [31:0] d0, input logic [31:0] d1, input bit bad);
    @(negedge clk_i);
    cmd_valid_i = 1'b1;
    cmd_data_i  = d0;
    @(negedge clk_i);
    if (bad) begin
      cmd_valid_i = 1'b0;
      chk(cmd_err_o == 1'b1, "R2 err pulse", 32'(cmd_err_o), 1);
      chk(flip_pending_o == 1'b0, "R2 no pending", 32'(flip_pending_o), 0);
      chk(disp_base_o == m_base && disp_pitch_o == m_pitch, "R2 state kept",
          32'(disp_base_o), 32'(m_base));
      @(negedge clk_i);
      chk(cmd_err_o == 1'b0, "R2 one-cycle err", 32'(cmd_err_o), 0);
    end else begin
      cmd_data_i = d1;
      @(negedge clk_i);
      cmd_valid_i = 1'b0;
      chk(cmd_err_o == 1'b0, "R2 good header no err", 32'(cmd_err_o), 0);
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(disp_base_o == '0, "R1 base", 32'(disp_base_o), 0);
    chk(disp_pitch_o == '0, "R1 pitch", 32'(disp_pitch_o), 0);
    chk(!flip_pending_o && !irq_o, "R1 flags", {30'd0, flip_pending_o, irq_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(cmd_ready_o == 1'b1, "R1 ready", 32'(cmd_ready_o), 1);

    for (int v = 0; v < NV; v++) begin
      vec_t e = VECS[v];
      bit bad = (e.cl != 3'd0) || (e.tg != 6'h14) || (e.len != 6'd0);
      logic [31:0] d0 = {e.cl, e.tg, 3'b000, e.pitch, 1'b0, e.async_f, e.len};
      logic [31:0] d1 = {6'd0, e.base, 3'b000};
      hws_mask_i = e.hm;
      irq_mask_i = e.im;
      irq_en_i   = e.ie;
      send(d0, d1, bad);
      if (!bad) begin
        chk(flip_pending_o == 1'b1, "R4 pending set", 32'(flip_pending_o), 1);
        chk(cmd_ready_o == 1'b0, "R4 ready low", 32'(cmd_ready_o), 0);
        chk(status_wr_o == !e.hm, "R9 set writeback", 32'(status_wr_o), 32'(!e.hm));
        @(negedge clk_i);
        chk(status_wr_o == 1'b0, "R9 one cycle", 32'(status_wr_o), 0);
        if (!e.async_f) begin
          hs_pulse();
          chk(disp_base_o == m_base && flip_pending_o, "R8 hsync ignored by sync flip",
              32'(disp_base_o), 32'(m_base));
          vsync_i = 1'b1;
          hsync_i = e.both;
          @(negedge clk_i);
          vsync_i = 1'b0;
          hsync_i = 1'b0;
          m_base  = e.base;
          m_pitch = e.pitch;
          chk(disp_base_o == m_base, "R5 R3 base", 32'(disp_base_o), 32'(m_base));
          chk(disp_pitch_o == m_pitch, "R5 R3 pitch", 32'(disp_pitch_o), 32'(m_pitch));
          chk(flip_pending_o == 1'b0, "R5 retired", 32'(flip_pending_o), 0);
        end else begin
          vsync_i = 1'b1;
          @(negedge clk_i) vsync_i = 1'b0;
          chk(disp_base_o == m_base && flip_pending_o, "R8 vsync ignored by async flip",
              32'(disp_base_o), 32'(m_base));
          hsync_i = 1'b1;
          vsync_i = e.both;
          @(negedge clk_i);
          hsync_i = 1'b0;
          vsync_i = 1'b0;
          m_base  = e.base;
          chk(disp_base_o == m_base, "R6 R3 base", 32'(disp_base_o), 32'(m_base));
          chk(disp_pitch_o == m_pitch, "R6 pitch kept", 32'(disp_pitch_o), 32'(m_pitch));
          chk(flip_pending_o == 1'b1, "R6 still pending", 32'(flip_pending_o), 1);
          for (int k = 0; k < 31; k++) begin
            @(negedge clk_i);
            hs_pulse();
          end
          chk(flip_pending_o == 1'b1, "R7 pending after 31", 32'(flip_pending_o), 1);
          @(negedge clk_i);
          hs_pulse();
          chk(flip_pending_o == 1'b0, "R7 cleared at 32", 32'(flip_pending_o), 0);
        end
        chk(status_wr_o == !e.hm, "R9 clear writeback", 32'(status_wr_o), 32'(!e.hm));
        @(negedge clk_i);
        chk(irq_o == (e.ie && !e.im), "R10 irq gating", 32'(irq_o), 32'(e.ie && !e.im));
        irq_clr_i = 1'b1;
        @(negedge clk_i) irq_clr_i = 1'b0;
        chk(irq_o == 1'b0, "R10 clear", 32'(irq_o), 0);
      end
    end

    // R10: set beats clear in the same cycle
    hws_mask_i = 1'b0;
    irq_mask_i = 1'b0;
    irq_en_i   = 1'b1;
    send({3'd0, 6'h14, 3'b000, 12'h0C0, 1'b0, 1'b0, 6'd0}, {6'd0, 23'h004000, 3'b000}, 1'b0);
    vsync_i = 1'b1;
    @(negedge clk_i) vsync_i = 1'b0;
    irq_clr_i = 1'b1;
    @(negedge clk_i) irq_clr_i = 1'b0;
    chk(irq_o == 1'b1, "R10 set wins over clear", 32'(irq_o), 1);
    chk(disp_pitch_o == 12'h0C0, "R3 pitch field", 32'(disp_pitch_o), 32'h0C0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule